// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between the memory stage of a 32-bit core and a word-organised data memory. The core presents a memory opcode together with the already computed effective address, the store source register and, for loads, the word the memory returns. The unit decodes the opcode into access width, direction and extension mode. It checks that the address is aligned to the access width and drives a word address and per-byte write enables. It places store bytes on the correct lanes and pulls the addressed byte or halfword out of the returned word, extending it to 32 bits.

Byte lanes follow big-endian numbering: byte offset 0 inside a word is the most significant byte. A misaligned access is not performed. It raises a one-cycle fault flag, writes no byte and produces no load result. Opcodes that are not memory accesses pass through without any effect.

Request outputs (address, enables, write data, read strobe, fault) appear one cycle after the request. The memory read word is sampled in that cycle, and the extended load result appears one cycle later.

Top module: `be_lsu_align`

## Requirements
- R1: Opcodes 0x0d (signed byte load), 0x0e (unsigned byte load), 0x11 (signed halfword load), 0x13 (unsigned halfword load), 0x14 (word load), 0x17 (byte store), 0x1f (halfword store) and 0x2a (word store) are memory accesses. Any other 6-bit opcode causes no enable, no read strobe, no fault and no load result.
- R2: One cycle after a valid memory request, `mem_addr` equals the effective address with its two low bits removed.
- R3: Write-enable bit k covers data bits 8k+7..8k. Byte offset o maps to lane 3-o, so offset 0 is bits 31..24. No more than one, two or four enables are ever set.
- R4: A byte store places the source's bits 7..0 on all four lanes and sets only enable bit 3-o.
- R5: A halfword store places the source's bits 15..0 on both halves and sets enables 4'b1100 at offset 0 or 4'b0011 at offset 2.
- R6: A word store at offset 0 drives the source word unchanged with enables 4'b1111.
- R7: A byte load returns the addressed lane, sign-extended for opcode 0x0d and zero-extended for 0x0e.
- R8: A halfword load returns bits 31..16 (offset 0) or 15..0 (offset 2), sign-extended for 0x11 and zero-extended for 0x13.
- R9: A word load at offset 0 returns the memory word unchanged.
- R10: A halfword access at an odd offset or a word access at a nonzero offset raises `fault` for one cycle, with all write enables low, no read strobe and no load result.
- R11: For an aligned load, `mem_re` is high one cycle after the request, `mem_rdata` is sampled in that cycle, and `ld_valid` with `ld_data` follows one cycle later.
- R12: After reset, all enables, strobes, flags, `mem_addr`, `mem_wdata` and `ld_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Primary opcode of the instruction |
| req_addr | input | AW (32) | Effective byte address |
| req_wdata | input | 32 | Store source register |
| mem_rdata | input | 32 | Word returned by memory while `mem_re` is high |
| mem_addr | output | AW-2 (30) | Word address to memory |
| mem_we | output | 4 | Byte-lane write enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-positioned store word |
| mem_re | output | 1 | Read strobe for an aligned load |
| fault | output | 1 | Misaligned access pulse |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
A load's result extraction and the request stage of the next access share a cycle when requests are issued back to back. The unit then drives the later access's enables and lanes while it extends the earlier access's returned word. The bench provokes this overlap with a signed halfword load followed at once by a byte store at another offset. In the shared cycle it compares both the extended load value and the store's enables and lane data against values worked out by hand.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      hit;
        logic      store;
        logic      uns;
        acc_size_e size;
    } acc_dec_t;

    localparam logic [5:0] OP_LDB  = 6'h0d;
    localparam logic [5:0] OP_LDBU = 6'h0e;
    localparam logic [5:0] OP_LDH  = 6'h11;
    localparam logic [5:0] OP_LDHU = 6'h13;
    localparam logic [5:0] OP_LDW  = 6'h14;
    localparam logic [5:0] OP_STB  = 6'h17;
    localparam logic [5:0] OP_STH  = 6'h1f;
    localparam logic [5:0] OP_STW  = 6'h2a;

endpackage

// File: rtl/be_lsu_decode.sv
module be_lsu_decode
    import be_lsu_pkg::*;
(
    input  logic [5:0] op_i,
    output acc_dec_t   dec_o
);
    always_comb begin
        dec_o = '{hit: 1'b0, store: 1'b0, uns: 1'b0, size: SZ_WORD};
        case (op_i)
            OP_LDB:  dec_o = '{hit: 1'b1, store: 1'b0, uns: 1'b0, size: SZ_BYTE};
            OP_LDBU: dec_o = '{hit: 1'b1, store: 1'b0, uns: 1'b1, size: SZ_BYTE};
            OP_LDH:  dec_o = '{hit: 1'b1, store: 1'b0, uns: 1'b0, size: SZ_HALF};
            OP_LDHU: dec_o = '{hit: 1'b1, store: 1'b0, uns: 1'b1, size: SZ_HALF};
            OP_LDW:  dec_o = '{hit: 1'b1, store: 1'b0, uns: 1'b0, size: SZ_WORD};
            OP_STB:  dec_o = '{hit: 1'b1, store: 1'b1, uns: 1'b0, size: SZ_BYTE};
            OP_STH:  dec_o = '{hit: 1'b1, store: 1'b1, uns: 1'b0, size: SZ_HALF};
            OP_STW:  dec_o = '{hit: 1'b1, store: 1'b1, uns: 1'b0, size: SZ_WORD};
            default: ;
        endcase
    end
endmodule

// File: rtl/be_lsu_store_lane.sv
module be_lsu_store_lane
    import be_lsu_pkg::*;
#(
    parameter int LANES = 4
) (
    input  acc_size_e          size_i,
    input  logic [1:0]         off_i,
    input  logic [8*LANES-1:0] src_i,
    output logic [LANES-1:0]   we_o,
    output logic [8*LANES-1:0] data_o
);
    localparam int LAST = LANES - 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [1:0] BOFF = 2'(LAST - k);
        localparam int HSEL = k % 2;
        always_comb begin
            case (size_i)
                SZ_BYTE: begin
                    we_o[k]          = (off_i == BOFF);
                    data_o[8*k +: 8] = src_i[7:0];
                end
                SZ_HALF: begin
                    we_o[k]          = (off_i[1] == BOFF[1]);
                    data_o[8*k +: 8] = src_i[8*HSEL +: 8];
                end
                default: begin
                    we_o[k]          = 1'b1;
                    data_o[8*k +: 8] = src_i[8*k +: 8];
                end
            endcase
        end
    end
endmodule

// File: rtl/be_lsu_load_extract.sv
module be_lsu_load_extract
    import be_lsu_pkg::*;
(
    input  acc_size_e   size_i,
    input  logic        uns_i,
    input  logic [1:0]  off_i,
    input  logic [31:0] word_i,
    output logic [31:0] data_o
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        byte_sel = word_i[8*(3 - int'(off_i)) +: 8];
        half_sel = off_i[1] ? word_i[15:0] : word_i[31:16];
        case (size_i)
            SZ_BYTE: data_o = {{24{byte_sel[7] & ~uns_i}}, byte_sel};
            SZ_HALF: data_o = {{16{half_sel[15] & ~uns_i}}, half_sel};
            default: data_o = word_i;
        endcase
    end
endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
    import be_lsu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [5:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [AW-3:0] mem_addr,
    output logic [3:0]    mem_we,
    output logic [31:0]   mem_wdata,
    output logic          mem_re,
    output logic          fault,
    output logic          ld_valid,
    output logic [31:0]   ld_data
);
    localparam int WA = AW - 2;

    typedef struct packed {
        logic [WA-1:0] mem_addr;
        logic [3:0]    mem_we;
        logic [31:0]   mem_wdata;
        logic          mem_re;
        logic          fault;
        logic [1:0]    ld_off;
        acc_size_e     ld_size;
        logic          ld_uns;
        logic          ld_valid;
        logic [31:0]   ld_data;
    } lsu_state_t;

    lsu_state_t st_d, st_q;
    acc_dec_t   dec;
    logic [1:0] off;
    logic       misalign;
    logic [3:0] lane_we;
    logic [31:0] lane_data;
    logic [31:0] ext_data;

    assign off = req_addr[1:0];

    be_lsu_decode u_dec (
        .op_i  (req_op),
        .dec_o (dec)
    );

    be_lsu_store_lane #(.LANES(4)) u_lane (
        .size_i (dec.size),
        .off_i  (off),
        .src_i  (req_wdata),
        .we_o   (lane_we),
        .data_o (lane_data)
    );

    be_lsu_load_extract u_ext (
        .size_i (st_q.ld_size),
        .uns_i  (st_q.ld_uns),
        .off_i  (st_q.ld_off),
        .word_i (mem_rdata),
        .data_o (ext_data)
    );

    always_comb begin
        misalign = ((dec.size == SZ_HALF) && off[0]) ||
                   ((dec.size == SZ_WORD) && (off != 2'd0));
        st_d          = st_q;
        st_d.mem_we   = '0;
        st_d.mem_re   = 1'b0;
        st_d.fault    = 1'b0;
        st_d.ld_valid = 1'b0;
        if (req_valid && dec.hit) begin
            st_d.mem_addr = req_addr[AW-1:2];
            if (misalign) begin
                st_d.fault = 1'b1;
            end else if (dec.store) begin
                st_d.mem_we    = lane_we;
                st_d.mem_wdata = lane_data;
            end else begin
                st_d.mem_re  = 1'b1;
                st_d.ld_off  = off;
                st_d.ld_size = dec.size;
                st_d.ld_uns  = dec.uns;
            end
        end
        if (st_q.mem_re) begin
            st_d.ld_valid = 1'b1;
            st_d.ld_data  = ext_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ld_size: SZ_BYTE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.mem_addr;
    assign mem_we    = st_q.mem_we;
    assign mem_wdata = st_q.mem_wdata;
    assign mem_re    = st_q.mem_re;
    assign fault     = st_q.fault;
    assign ld_valid  = st_q.ld_valid;
    assign ld_data   = st_q.ld_data;
endmodule

// File: rtl/be_lsu_align_chk.sv
module be_lsu_align_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mem_we,
    input logic       mem_re,
    input logic       fault,
    input logic       ld_valid
);
    assert_fault_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (mem_we == 4'b0000) && !mem_re);

    assert_lane_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
                       4'b0011, 4'b1100, 4'b1111});

    assert_read_then_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ld_valid);

    assert_result_has_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_re));

    assert_read_not_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_we == 4'b0000));

    assert_fault_no_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !ld_valid);
endmodule

bind be_lsu_align be_lsu_align_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .fault    (fault),
    .ld_valid (ld_valid)
);

// File: tb/sim_be_lsu_align.sv
module sim_be_lsu_align;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic [29:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        mem_re;
    logic        fault;
    logic        ld_valid;
    logic [31:0] ld_data;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    be_lsu_align u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .fault(fault), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // op -> {hit, store, unsigned, size}; size 0 byte, 1 half, 2 word
    function automatic logic [4:0] ref_dec(input logic [5:0] op);
        case (op)
            6'h0d: return {1'b1, 1'b0, 1'b0, 2'd0};
            6'h0e: return {1'b1, 1'b0, 1'b1, 2'd0};
            6'h11: return {1'b1, 1'b0, 1'b0, 2'd1};
            6'h13: return {1'b1, 1'b0, 1'b1, 2'd1};
            6'h14: return {1'b1, 1'b0, 1'b0, 2'd2};
            6'h17: return {1'b1, 1'b1, 1'b0, 2'd0};
            6'h1f: return {1'b1, 1'b1, 1'b0, 2'd1};
            6'h2a: return {1'b1, 1'b1, 1'b0, 2'd2};
            default: return 5'd0;
        endcase
    endfunction

    task automatic run_one(input logic [5:0] op, input logic [31:0] addr,
                           input logic [31:0] wd, input logic [31:0] rd);
        logic [4:0]  d;
        logic [1:0]  o;
        logic        mis;
        logic [3:0]  ewe;
        logic [31:0] ewd;
        logic [31:0] eld;
        logic [7:0]  b;
        logic [15:0] h;
        string       tg;
        d = ref_dec(op);
        o = addr[1:0];
        mis = d[4] && (((d[1:0] == 2'd1) && o[0]) || ((d[1:0] == 2'd2) && (o != 2'd0)));
        ewe = 4'd0;
        ewd = 32'd0;
        eld = 32'd0;
        b = rd[8*(3 - int'(o)) +: 8];
        h = o[1] ? rd[15:0] : rd[31:16];
        case (d[1:0])
            2'd0: begin
                ewe = 4'(1 << (3 - int'(o)));
                ewd = {4{wd[7:0]}};
                eld = d[2] ? {24'd0, b} : {{24{b[7]}}, b};
                tg  = d[3] ? "R4" : "R7";
            end
            2'd1: begin
                ewe = o[1] ? 4'b0011 : 4'b1100;
                ewd = {2{wd[15:0]}};
                eld = d[2] ? {16'd0, h} : {{16{h[15]}}, h};
                tg  = d[3] ? "R5" : "R8";
            end
            default: begin
                ewe = 4'b1111;
                ewd = wd;
                eld = rd;
                tg  = d[3] ? "R6" : "R9";
            end
        endcase
        if (!d[4]) tg = "R1";
        else if (mis) tg = "R10";

        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; mem_rdata = rd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(fault == (d[4] && mis), {tg, " fault"}, 32'(fault), 32'(d[4] && mis));
        chk(mem_re == (d[4] && !d[3] && !mis), {tg, " R11 mem_re"}, 32'(mem_re),
            32'(d[4] && !d[3] && !mis));
        if (d[4] && d[3] && !mis) begin
            chk(mem_we == ewe, {tg, " R3 enables"}, 32'(mem_we), 32'(ewe));
            chk(mem_wdata == ewd, {tg, " lane data"}, mem_wdata, ewd);
        end else begin
            chk(mem_we == 4'd0, {tg, " no enables"}, 32'(mem_we), 32'd0);
        end
        if (d[4]) chk(mem_addr == addr[31:2], "R2 word address", 32'(mem_addr), 32'(addr[31:2]));
        @(negedge clk);
        if (d[4] && !d[3] && !mis) begin
            chk(ld_valid == 1'b1, {tg, " R11 ld_valid"}, 32'(ld_valid), 32'd1);
            chk(ld_data == eld, {tg, " load value"}, ld_data, eld);
        end else begin
            chk(ld_valid == 1'b0, {tg, " no result"}, 32'(ld_valid), 32'd0);
        end
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [5:0]  mops [8];
        logic [31:0] rpat [3];
        logic [31:0] wpat [3];
        mops = '{6'h0d, 6'h0e, 6'h11, 6'h13, 6'h14, 6'h17, 6'h1f, 6'h2a};
        rpat = '{32'h80FF7F01, 32'h7F80C3A5, 32'h00FF8001};
        wpat = '{32'hA5C396F0, 32'h12345678, 32'hFF00807F};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(mem_we == 4'd0 && !mem_re && !fault && !ld_valid, "R12 flags", 
            {mem_we, mem_re, fault, ld_valid}, 32'd0);
        chk(mem_addr == 30'd0 && mem_wdata == 32'd0 && ld_data == 32'd0, "R12 data",
            mem_wdata | ld_data | 32'(mem_addr), 32'd0);

        // sweep every memory opcode, offset and pattern
        for (int i = 0; i < 8; i++)
            for (int o = 0; o < 4; o++)
                for (int p = 0; p < 3; p++)
                    run_one(mops[i], (32'h0ABCDE00 ^ (32'(p) << 9) ^ (32'(i) << 20)) | 32'(o),
                            wpat[p], rpat[(p + o) % 3]);

        // R1: every other opcode is inert, even at an odd address
        for (int op = 0; op < 64; op++)
            if (!ref_dec(6'(op))[4]) run_one(6'(op), 32'h00001233, 32'hDEADBEEF, 32'h89ABCDEF);

        // overlap: signed halfword load, then byte store next cycle
        req_valid = 1'b1; req_op = 6'h11; req_addr = 32'h00004442;
        req_wdata = 32'h0; mem_rdata = 32'h12348001;
        @(negedge clk);
        chk(mem_re == 1'b1, "R11 overlap read", 32'(mem_re), 32'd1);
        req_op = 6'h17; req_addr = 32'h00008881; req_wdata = 32'h1111115A;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ld_valid && ld_data == 32'hFFFF8001, "R8 overlap load", ld_data, 32'hFFFF8001);
        chk(mem_we == 4'b0100, "R4 overlap enables", 32'(mem_we), 32'h4);
        chk(mem_wdata == 32'h5A5A5A5A, "R4 overlap lanes", mem_wdata, 32'h5A5A5A5A);
        chk(mem_addr == 30'h2220, "R2 overlap address", 32'(mem_addr), 32'h2220);
        @(negedge clk);
        chk(!ld_valid && mem_we == 4'd0, "R11 overlap idle", {ld_valid, mem_we}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule